// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block turns a vector operation of any element count into a series of pieces, none longer than the hardware's maximum vector length. For each piece it presents a starting element index, a length value for the vector-length register, and the byte address of that piece's first element. A downstream element engine walks each piece at one element per clock and answers with a one-cycle completion pulse. When the last piece completes, the block raises a one-cycle done pulse.

The piece that does not fill a whole maximum length, of size n mod MAX_VL, goes out first. Every piece after it is a full MAX_VL elements, and each piece starts where the previous one ended. If n is an exact multiple of MAX_VL, the empty leading piece is skipped. Elements are 8 bytes wide by default, so each piece address is the captured base plus eight times the start index.

Top module: `vl_strip_seq`

## Requirements
- R1: After reset, piece_valid_o, busy_o and done_o are all 0.
- R2: For a nonzero n whose remainder n mod MAX_VL is nonzero, the first piece has low_idx_o = 0 and vl_o equal to that remainder.
- R3: Every piece after the first has vl_o = MAX_VL. When the remainder is zero, the first piece is also MAX_VL long.
- R4: The start index of each piece equals the previous piece's start index plus its length. The first index is 0.
- R5: A run issues floor(n/MAX_VL) pieces, plus one more when n mod MAX_VL is nonzero. A zero-length piece never raises piece_valid_o.
- R6: A start with n = 0 raises done_o in the cycle right after the start is sampled, and no piece is issued.
- R7: While piece_valid_o is 1, piece_addr_o equals the base captured at start plus low_idx_o times ELEM_BYTES (8).
- R8: A start_i pulse while busy_o is 1 has no effect. The current piece's index, length and address, and the rest of the run, continue unchanged.
- R9: piece_valid_o stays 1 with stable low_idx_o and vl_o until piece_done_i is sampled. It then drops for exactly one cycle before the next piece is presented.
- R10: After the final piece_done_i, done_o is 1 for exactly one cycle, and busy_o is 0 in that cycle and afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run; sampled only when idle |
| total_len_i | input | LEN_W | Total element count n |
| base_addr_i | input | ADDR_W | Byte address of element 0 |
| piece_done_i | input | 1 | Engine has finished the current piece |
| piece_valid_o | output | 1 | A piece is presented to the engine |
| low_idx_o | output | LEN_W | Start element index of the piece |
| vl_o | output | VL_W | Vector length of the piece |
| piece_addr_o | output | ADDR_W | Byte address of the piece's first element |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |

## Verification
The assertions check the following on every cycle:
- the bounds on each piece length;
- that every later piece is full length;
- the index step from one piece to the next;
- the address formula against a base the checker captures itself;
- that a piece holds steady until completion, followed by the single gap cycle;
- that an n = 0 start finishes at once;
- that done is a single pulse.

Only the bench scenarios can show the total number of pieces, the first-piece remainder for each n, and the skipped empty piece on exact multiples. They sweep every n from 0 upward across several multiples of a small maximum length. The same is true of a start pulse landing mid-run, which leaves the whole remaining sequence unchanged.

// File: rtl/strip_pkg.sv
package strip_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/strip_first_len.sv
// Length of the leading odd-size piece: n mod MAX_VL.
module strip_first_len #(
    parameter int MAX_VL = 64,
    parameter int LEN_W  = 16,
    parameter int VL_W   = 7
) (
    input  logic [LEN_W-1:0] total_i,
    output logic [VL_W-1:0]  rem_o
);
    localparam bit IS_POW2 = ((MAX_VL & (MAX_VL - 1)) == 0);
    localparam int SH      = $clog2(MAX_VL);

    generate
        if (IS_POW2 && SH == 0) begin : g_unit
            assign rem_o = '0;
        end else if (IS_POW2) begin : g_slice
            // power of two: remainder is just the low bits
            assign rem_o = VL_W'(total_i[SH-1:0]);
        end else begin : g_mod
            logic [LEN_W-1:0] m;
            assign m     = total_i % LEN_W'(MAX_VL);
            assign rem_o = VL_W'(m);
        end
    endgenerate
endmodule

// File: rtl/strip_addr_gen.sv
// Byte address of a piece: base + low * ELEM_BYTES.
module strip_addr_gen #(
    parameter int LEN_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int ELEM_BYTES = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  low_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam bit IS_POW2 = ((ELEM_BYTES & (ELEM_BYTES - 1)) == 0);
    localparam int SH      = $clog2(ELEM_BYTES);

    generate
        if (IS_POW2) begin : g_shift
            assign addr_o = base_i + (ADDR_W'(low_i) << SH);
        end else begin : g_mul
            assign addr_o = base_i + ADDR_W'(low_i) * ADDR_W'(ELEM_BYTES);
        end
    endgenerate
endmodule

// File: rtl/vl_strip_seq.sv
module vl_strip_seq #(
    parameter int MAX_VL     = 64,
    parameter int LEN_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int ELEM_BYTES = 8,
    localparam int VL_W      = $clog2(MAX_VL + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  total_len_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic              piece_done_i,
    output logic              piece_valid_o,
    output logic [LEN_W-1:0]  low_idx_o,
    output logic [VL_W-1:0]   vl_o,
    output logic [ADDR_W-1:0] piece_addr_o,
    output logic              busy_o,
    output logic              done_o
);
    import strip_pkg::*;

    localparam logic [VL_W-1:0]  FULL_VL  = VL_W'(MAX_VL);
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_VL);

    typedef struct packed {
        seq_state_e        state;
        logic [LEN_W-1:0]  low;
        logic [VL_W-1:0]   vl;
        logic [LEN_W-1:0]  remain;
        logic [ADDR_W-1:0] base;
        logic              done;
    } seq_regs_t;

    seq_regs_t       seq_d, seq_q;
    logic [VL_W-1:0] rem_len;

    strip_first_len #(
        .MAX_VL (MAX_VL),
        .LEN_W  (LEN_W),
        .VL_W   (VL_W)
    ) u_first_len (
        .total_i (total_len_i),
        .rem_o   (rem_len)
    );

    strip_addr_gen #(
        .LEN_W      (LEN_W),
        .ADDR_W     (ADDR_W),
        .ELEM_BYTES (ELEM_BYTES)
    ) u_addr_gen (
        .base_i (seq_q.base),
        .low_i  (seq_q.low),
        .addr_o (piece_addr_o)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.base = base_addr_i;
                    seq_d.low  = '0;
                    if (total_len_i == '0) begin
                        seq_d.done = 1'b1;
                    end else if (rem_len != '0) begin
                        // odd-size piece goes first
                        seq_d.vl     = rem_len;
                        seq_d.remain = total_len_i - LEN_W'(rem_len);
                        seq_d.state  = ST_ISSUE;
                    end else begin
                        // exact multiple: empty leading piece is skipped
                        seq_d.vl     = FULL_VL;
                        seq_d.remain = total_len_i - FULL_LEN;
                        seq_d.state  = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (piece_done_i) begin
                    if (seq_q.remain == '0) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                    end else begin
                        seq_d.low    = seq_q.low + LEN_W'(seq_q.vl);
                        seq_d.vl     = FULL_VL;
                        seq_d.remain = seq_q.remain - FULL_LEN;
                        seq_d.state  = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                seq_d.state = ST_ISSUE;
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign piece_valid_o = (seq_q.state == ST_ISSUE);
    assign busy_o        = (seq_q.state != ST_IDLE);
    assign low_idx_o     = seq_q.low;
    assign vl_o          = seq_q.vl;
    assign done_o        = seq_q.done;
endmodule

// File: rtl/strip_seq_checker.sv
module strip_seq_checker #(
    parameter int MAX_VL     = 64,
    parameter int LEN_W      = 16,
    parameter int ADDR_W     = 32,
    parameter int ELEM_BYTES = 8,
    parameter int VL_W       = 7
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic [LEN_W-1:0]  total_len_i,
    input logic [ADDR_W-1:0] base_addr_i,
    input logic              piece_done_i,
    input logic              piece_valid_o,
    input logic [LEN_W-1:0]  low_idx_o,
    input logic [VL_W-1:0]   vl_o,
    input logic [ADDR_W-1:0] piece_addr_o,
    input logic              busy_o,
    input logic              done_o
);
    logic [ADDR_W-1:0] cap_base;
    logic [LEN_W-1:0]  prev_end;
    logic              first_pending;
    logic [ADDR_W-1:0] exp_addr;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cap_base      <= '0;
            prev_end      <= '0;
            first_pending <= 1'b0;
        end else begin
            if (start_i && !busy_o) begin
                cap_base      <= base_addr_i;
                first_pending <= 1'b1;
            end
            if (piece_valid_o && piece_done_i) begin
                first_pending <= 1'b0;
                prev_end      <= low_idx_o + LEN_W'(vl_o);
            end
        end
    end

    assign exp_addr = cap_base + ADDR_W'(low_idx_o) * ADDR_W'(ELEM_BYTES);

    AST_VL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        piece_valid_o |-> (vl_o != '0) && (vl_o <= VL_W'(MAX_VL))); // R5
    AST_FIRST_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (piece_valid_o && first_pending) |-> (low_idx_o == '0)); // R2
    AST_LATER_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (piece_valid_o && !first_pending) |-> (vl_o == VL_W'(MAX_VL))); // R3
    AST_INDEX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (piece_valid_o && !first_pending) |-> (low_idx_o == prev_end)); // R4
    AST_ADDR_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        piece_valid_o |-> (piece_addr_o == exp_addr)); // R7
    AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && piece_valid_o && !piece_done_i) |=>
            (piece_valid_o && $stable(piece_addr_o))); // R8
    AST_PIECE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (piece_valid_o && !piece_done_i) |=>
            (piece_valid_o && $stable(low_idx_o) && $stable(vl_o))); // R9
    AST_PIECE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (piece_valid_o && piece_done_i) |=> !piece_valid_o); // R9
    AST_ZERO_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o && total_len_i == '0) |=> (done_o && !busy_o)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R10
    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o); // R10
endmodule

bind vl_strip_seq strip_seq_checker #(
    .MAX_VL     (MAX_VL),
    .LEN_W      (LEN_W),
    .ADDR_W     (ADDR_W),
    .ELEM_BYTES (ELEM_BYTES),
    .VL_W       (VL_W)
) u_strip_seq_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .total_len_i   (total_len_i),
    .base_addr_i   (base_addr_i),
    .piece_done_i  (piece_done_i),
    .piece_valid_o (piece_valid_o),
    .low_idx_o     (low_idx_o),
    .vl_o          (vl_o),
    .piece_addr_o  (piece_addr_o),
    .busy_o        (busy_o),
    .done_o        (done_o)
);

// File: tb/test_vl_strip_seq.sv
module test_vl_strip_seq;
    localparam int MVL   = 4;
    localparam int LW    = 6;
    localparam int AW    = 16;
    localparam int EB    = 8;
    localparam int VW    = $clog2(MVL + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] tlen = '0;
    logic [AW-1:0] baddr = '0;
    logic          pdone = 1'b0;
    logic          pvalid;
    logic [LW-1:0] low;
    logic [VW-1:0] vl;
    logic [AW-1:0] paddr;
    logic          busy;
    logic          done;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    vl_strip_seq #(
        .MAX_VL     (MVL),
        .LEN_W      (LW),
        .ADDR_W     (AW),
        .ELEM_BYTES (EB)
    ) i_vl_strip_seq (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .start_i       (start),
        .total_len_i   (tlen),
        .base_addr_i   (baddr),
        .piece_done_i  (pdone),
        .piece_valid_o (pvalid),
        .low_idx_o     (low),
        .vl_o          (vl),
        .piece_addr_o  (paddr),
        .busy_o        (busy),
        .done_o        (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int n, input logic [AW-1:0] base, input bit poke);
        int rem = n % MVL;
        int npieces = n / MVL + ((rem != 0) ? 1 : 0);
        int lo = 0;
        @(negedge clk);
        start = 1'b1; tlen = LW'(n); baddr = base;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            chk(done == 1'b1, "R6 done after zero-length start", int'(done), 1);
            chk(pvalid == 1'b0, "R6 no piece for zero length", int'(pvalid), 0);
            @(negedge clk);
            chk(done == 1'b0, "R10 done single cycle", int'(done), 0);
            return;
        end
        for (int p = 0; p < npieces; p++) begin
            int exp_vl = (p == 0 && rem != 0) ? rem : MVL;
            int hold;
            chk(pvalid == 1'b1, "R9 piece presented", int'(pvalid), 1);
            if (p == 0)
                chk(int'(vl) == exp_vl, (rem != 0) ? "R2 first piece length" : "R5 empty piece skipped", int'(vl), exp_vl);
            else
                chk(int'(vl) == exp_vl, "R3 later piece full length", int'(vl), exp_vl);
            chk(int'(low) == lo, "R4 piece start index", int'(low), lo);
            chk(int'(paddr) == int'(AW'(int'(base) + lo * EB)), "R7 piece address",
                int'(paddr), int'(AW'(int'(base) + lo * EB)));
            hold = int'(vl);
            for (int c = 0; c < hold; c++) begin
                if (poke && p == 1 && c == 0) begin
                    start = 1'b1; tlen = LW'(7); baddr = 16'hBEE0;
                end
                @(negedge clk);
                start = 1'b0; tlen = LW'(n); baddr = base;
            end
            chk(pvalid == 1'b1 && int'(low) == lo && int'(vl) == exp_vl,
                poke ? "R8 mid-run start ignored" : "R9 piece held until done",
                int'(low), lo);
            chk(int'(paddr) == int'(AW'(int'(base) + lo * EB)), "R8 address unchanged",
                int'(paddr), int'(AW'(int'(base) + lo * EB)));
            pdone = 1'b1;
            @(negedge clk);
            pdone = 1'b0;
            lo += exp_vl;
            if (p == npieces - 1) begin
                chk(done == 1'b1, "R5 done after last piece", int'(done), 1);
                chk(pvalid == 1'b0 && busy == 1'b0, "R10 idle at done", int'(busy), 0);
                @(negedge clk);
                chk(done == 1'b0, "R10 done single cycle", int'(done), 0);
            end else begin
                chk(pvalid == 1'b0 && done == 1'b0, "R9 one-cycle gap", int'(pvalid), 0);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pvalid == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 reset state", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pvalid == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'(pvalid), 0);
        for (int n = 0; n <= 21; n++) begin
            run_case(n, AW'(16'h1000 + n * 16'h0123), n == 13);
        end
        run_case(9, 16'h2F00, 1'b1);
        run_case(8, 16'h0040, 1'b1);
        run_case(0, 16'h0000, 1'b0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule